// File: doc/BRIEF.md
# Serially Programmed Clock Fanout Gate

This block sends one input clock out on eighteen outputs. Each output has its own enable bit, and an enable can be changed over a two-wire serial bus. The serial side is a target-only I2C receiver/transmitter. It oversamples SCL and SDA with a fast system clock and holds three 8-bit enable registers. A write transfer starts with two throw-away bytes and then fills the registers in ascending order. A read transfer always begins at the first register and continues in sequence for as long as the bus master acknowledges.

Each enable bit is carried into the input-clock domain. It takes effect only on a falling edge of that clock, so an output either copies the input clock or sits low, and no runt pulse appears. An active-low float input turns off the drivers of all eighteen outputs. The pad ring turns a low per-pin drive flag into high impedance.

Top module: `clkFanoutGate`

## Requirements
- R1: The block acknowledges the 7-bit target address 0x69, which gives an address byte of 0xD2 for writes and 0xD3 for reads (R/W is the LSB, 1 = read). It does not acknowledge any other address, and a transfer to another address leaves the registers unchanged.
- R2: In a write, the block acknowledges the first two bytes after the address and discards them. The 3rd, 4th and 5th bytes load registers 0, 1 and 2 in that order.
- R3: A write that ends after any complete byte keeps every register it already loaded. Registers it did not reach keep their old values.
- R4: Data bytes after the fifth byte of one write are acknowledged and discarded.
- R5: A read returns register 0, then 1, then 2, then wraps back to register 0. The transfer continues while the master acknowledges and ends at the master's NACK.
- R6: After reset every register bit is 1, so all eighteen outputs pass the input clock, and SDA is released.
- R7: Output k (k = 0 to 7) is enabled by register 0 bit k. Output 8+k (k = 0 to 7) is enabled by register 2 bit k. Outputs 16 and 17 are enabled by register 1 bits 6 and 7. Register 1 bits 5:0 are stored and read back unchanged.
- R8: An output whose enable is 1 equals the input clock. An output whose enable is 0 is held at 0.
- R9: Enable changes take effect only while the input clock is low. An output never changes level while the input clock stays high.
- R10: When `floatN` is 0, every `clkDrive` bit is 0 (high impedance), whatever the registers hold. When `floatN` is 1, every `clkDrive` bit is 1.
- R11: The block pulls SDA low only while SCL is low. START and STOP are recognised as SDA edges while SCL is high, with SCL and SDA sampled by `clk` at no less than 8 times the bit rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial bus clock line |
| sdaIn | input | 1 | Serial bus data line, as seen on the wire |
| sdaOe | output | 1 | 1 pulls SDA low (open drain) |
| bufClk | input | 1 | Clock to be fanned out |
| floatN | input | 1 | 0 puts all clock outputs in high impedance |
| clkOut | output | 18 | Gated copies of `bufClk` |
| clkDrive | output | 18 | Per-output driver enable, 0 = high impedance |

## Verification
A register write lands a few `clk` cycles after the falling SCL edge that closes its byte. The new enable then needs two falling edges of `bufClk` before it reaches an output. The bench therefore pauses its output comparison from the start of each write until four `bufClk` falling edges after the STOP. Outside those windows it compares every output against its own register model on every `bufClk` edge, sampling 2 ns after the edge. Acknowledge bits and read data are sampled in the middle of the SCL high phase, which is at least four `clk` cycles after the block has had the chance to move SDA. The float input acts without any register, so its effect is checked at the same sampling points.

// File: rtl/clkFanoutPkg.sv
package clkFanoutPkg;
  localparam int NUM_REGS    = 3;
  localparam int NUM_OUTS    = 18;
  localparam int DUMMY_BYTES = 2;
  localparam int IDX_W       = $clog2(NUM_REGS);

  // strobes from the bus controller to the register datapath
  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic [7:0]       wrData;
    logic [IDX_W-1:0] rdIdx;
  } regStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } busState_t;
endpackage

// File: rtl/fanoutI2cCtrl.sv
module fanoutI2cCtrl
  import clkFanoutPkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdData,
  output logic       sdaOe,
  output regStrobe_t strobe
);
  localparam logic [2:0] FIRST_DATA = 3'(DUMMY_BYTES);
  localparam logic [2:0] BYTE_SAT   = 3'(DUMMY_BYTES + NUM_REGS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  logic [SYNC_STAGES-1:0] sclSh, sdaSh;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet;

  busState_t        state;
  logic [3:0]       bitCnt;
  logic [7:0]       shReg;
  logic [2:0]       byteCnt;
  logic [IDX_W-1:0] rdPtr;
  logic             rwBit, mAck;
  logic             wrEnQ;
  logic [IDX_W-1:0] wrIdxQ;
  logic [7:0]       wrDataQ;

  // two-flop (or deeper) synchronisers; bus idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh   <= '1;
      sdaSh   <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSh   <= {sclSh[SYNC_STAGES-2:0], sclIn};
      sdaSh   <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclSh[SYNC_STAGES-1];
  assign sdaS     = sdaSh[SYNC_STAGES-1];
  assign sclRise  = sclS && !sclPrev;
  assign sclFall  = !sclS && sclPrev;
  assign startDet = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopDet  = sclS && sclPrev && !sdaPrev && sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      shReg   <= '0;
      byteCnt <= '0;
      rdPtr   <= '0;
      rwBit   <= 1'b0;
      mAck    <= 1'b0;
      sdaOe   <= 1'b0;
      wrEnQ   <= 1'b0;
      wrIdxQ  <= '0;
      wrDataQ <= '0;
    end else begin
      wrEnQ <= 1'b0;
      if (startDet) begin
        state   <= ST_ADDR;
        bitCnt  <= '0;
        byteCnt <= '0;
        rdPtr   <= '0;
        sdaOe   <= 1'b0;
      end else if (stopDet) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (sclRise) begin
              shReg  <= {shReg[6:0], sdaS};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              if (shReg[7:1] == TARGET_ADDR) begin
                sdaOe <= 1'b1;
                rwBit <= shReg[0];
                state <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (sclFall) begin
              if (rwBit) begin
                shReg  <= rdData;
                sdaOe  <= ~rdData[7];
                bitCnt <= 4'd1;
                state  <= ST_RD;
              end else begin
                sdaOe <= 1'b0;
                state <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (sclRise) begin
              shReg  <= {shReg[6:0], sdaS};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              sdaOe  <= 1'b1;
              state  <= ST_WR_ACK;
              if (byteCnt >= FIRST_DATA && byteCnt < BYTE_SAT) begin
                wrEnQ   <= 1'b1;
                wrIdxQ  <= IDX_W'(byteCnt - FIRST_DATA);
                wrDataQ <= shReg;
              end
              if (byteCnt != BYTE_SAT) byteCnt <= byteCnt + 3'd1;
            end
          end
          ST_WR_ACK: begin
            if (sclFall) begin
              sdaOe <= 1'b0;
              state <= ST_WR;
            end
          end
          ST_RD: begin
            if (sclFall) begin
              if (bitCnt == 4'd8) begin
                sdaOe <= 1'b0;
                state <= ST_RD_ACK;
              end else begin
                sdaOe  <= ~shReg[6];
                shReg  <= {shReg[6:0], 1'b0};
                bitCnt <= bitCnt + 4'd1;
              end
            end
          end
          ST_RD_ACK: begin
            if (sclRise) begin
              mAck  <= ~sdaS;
              rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
            end else if (sclFall) begin
              if (mAck) begin
                shReg  <= rdData;
                sdaOe  <= ~rdData[7];
                bitCnt <= 4'd1;
                state  <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign strobe = '{wrEn: wrEnQ, wrIdx: wrIdxQ, wrData: wrDataQ, rdIdx: rdPtr};
endmodule

// File: rtl/fanoutRegFile.sv
module fanoutRegFile
  import clkFanoutPkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  regStrobe_t                strobe,
  output logic [7:0]                rdData,
  output logic [NUM_OUTS-1:0]       enVec,
  output logic [NUM_REGS*8-1:0]     regFlat
);
  logic [NUM_REGS-1:0][7:0] regQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ <= '1;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (strobe.wrEn && strobe.wrIdx == IDX_W'(r)) regQ[r] <= strobe.wrData;
      end
    end
  end

  always_comb begin
    rdData = regQ[0];
    for (int r = 1; r < NUM_REGS; r++) begin
      if (strobe.rdIdx == IDX_W'(r)) rdData = regQ[r];
    end
  end

  // non-contiguous bit-to-output map
  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_map
    if (i < 8) begin : g_lo
      assign enVec[i] = regQ[0][i];
    end else if (i < 16) begin : g_mid
      assign enVec[i] = regQ[2][i-8];
    end else begin : g_hi
      assign enVec[i] = regQ[1][i-10];
    end
  end

  assign regFlat = regQ;
endmodule

// File: rtl/fanoutGateBank.sv
module fanoutGateBank #(
  parameter int NUM_OUTS    = 18,
  parameter int GATE_STAGES = 2
) (
  input  logic                rstN,
  input  logic                bufClk,
  input  logic                floatN,
  input  logic [NUM_OUTS-1:0] enIn,
  output logic [NUM_OUTS-1:0] clkOut,
  output logic [NUM_OUTS-1:0] clkDrive
);
  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_gate
    logic [GATE_STAGES-1:0] enSync;
    // falling-edge synchroniser: the enable only moves while bufClk is low
    always_ff @(negedge bufClk or negedge rstN) begin
      if (!rstN) enSync <= '1;
      else       enSync <= {enSync[GATE_STAGES-2:0], enIn[i]};
    end
    assign clkOut[i]   = bufClk & enSync[GATE_STAGES-1];
    assign clkDrive[i] = floatN;
  end
endmodule

// File: rtl/clkFanoutGate.sv
module clkFanoutGate
  import clkFanoutPkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h69,
  parameter int         SYNC_STAGES = 2,
  parameter int         GATE_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  output logic                sdaOe,
  input  logic                bufClk,
  input  logic                floatN,
  output logic [NUM_OUTS-1:0] clkOut,
  output logic [NUM_OUTS-1:0] clkDrive
);
  regStrobe_t               ctlStrobe;
  logic [7:0]               rdData;
  logic [NUM_OUTS-1:0]      enVec;
  logic [NUM_REGS*8-1:0]    regFlat;

  fanoutI2cCtrl #(.TARGET_ADDR(TARGET_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .sdaOe(sdaOe), .strobe(ctlStrobe)
  );

  fanoutRegFile u_regs (
    .clk(clk), .rstN(rstN), .strobe(ctlStrobe),
    .rdData(rdData), .enVec(enVec), .regFlat(regFlat)
  );

  fanoutGateBank #(.NUM_OUTS(NUM_OUTS), .GATE_STAGES(GATE_STAGES)) u_gates (
    .rstN(rstN), .bufClk(bufClk), .floatN(floatN), .enIn(enVec),
    .clkOut(clkOut), .clkDrive(clkDrive)
  );
endmodule

// File: rtl/clkFanoutGateChk.sv
module clkFanoutGateChk
  import clkFanoutPkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  bufClk,
  input logic                  sclIn,
  input logic                  sdaOe,
  input logic [NUM_OUTS-1:0]   clkOut,
  input regStrobe_t            strobe,
  input logic [NUM_REGS*8-1:0] regFlat
);
  // valid while a bufClk high phase is longer than one clk period
  AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rstN)
    (bufClk && $past(bufClk)) |-> (clkOut == $past(clkOut))); // R9

  AST_ACK_ON_LOW_SCL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !$past(sclIn)); // R11

  AST_WR_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (strobe.wrIdx < IDX_W'(NUM_REGS))); // R2

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> $stable(regFlat)); // R3
endmodule

bind clkFanoutGate clkFanoutGateChk u_chk (
  .clk(clk), .rstN(rstN), .bufClk(bufClk), .sclIn(sclIn), .sdaOe(sdaOe),
  .clkOut(clkOut), .strobe(ctlStrobe), .regFlat(regFlat)
);

// File: tb/clkFanoutGate_tb.sv
`timescale 1ns/100ps
module clkFanoutGate_tb;
  localparam real CLK_PERIOD = 10.0;
  localparam real BUF_HALF   = 13.4;
  localparam int  QT         = 4;
  localparam int  WATCHDOG   = 150000;

  logic clk = 1'b0, rstN = 1'b0, bufClk = 1'b0;
  logic sdaM = 1'b1, sclM = 1'b1, floatN = 1'b1;
  logic sdaOe, sdaLine;
  logic [17:0] clkOut, clkDrive;

  assign sdaLine = sdaM & ~sdaOe;

  clkFanoutGate u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .bufClk(bufClk), .floatN(floatN), .clkOut(clkOut), .clkDrive(clkDrive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  initial begin
    #3;
    forever #(BUF_HALF) bufClk = ~bufClk;
  end

  int checks = 0, fails = 0;
  bit settling = 1'b1, done = 1'b0;
  logic [7:0] mReg [3];
  int runtCnt = 0, sdaBadCnt = 0;
  realtime riseT = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expEn(input int i);
    if (i < 8)       return mReg[0][i];
    else if (i < 16) return mReg[2][i-8];
    else if (i == 16) return mReg[1][6];
    else             return mReg[1][7];
  endfunction

  // reference model comparison on every bufClk edge (R8, R10, R7)
  always @(bufClk) begin
    logic [17:0] e;
    #2;
    if (rstN && !settling && !done) begin
      for (int i = 0; i < 18; i++) e[i] = bufClk & expEn(i);
      chk(clkOut === e, "R8", clkOut, e);
      chk(clkDrive === {18{floatN}}, "R10", clkDrive, {18{floatN}});
    end
  end

  // R9: no output change while bufClk is high
  always @(posedge bufClk) riseT = $realtime;
  always @(clkOut) begin
    #0.1;
    if (rstN && bufClk && ($realtime - riseT) > 0.15) runtCnt++;
  end
  // R11: SDA pulled only while SCL low
  always @(posedge sdaOe) if (sclM) sdaBadCnt++;

  task automatic waitQ();
    repeat (QT) @(posedge clk);
    #0.5;
  endtask

  task automatic i2cStart();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ();
      sclM = 1'b1; waitQ(); waitQ();
      sclM = 1'b0; waitQ();
    end
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    ack = (sdaLine == 1'b0);
    waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; waitQ();
      sclM = 1'b1; waitQ();
      d[i] = sdaLine;
      waitQ();
      sclM = 1'b0; waitQ();
    end
    sdaM = giveAck ? 1'b0 : 1'b1; waitQ();
    sclM = 1'b1; waitQ(); waitQ();
    sclM = 1'b0; waitQ();
    sdaM = 1'b1;
  endtask

  // bytes packed MSB first, n of them
  task automatic writeTx(input logic [7:0] addr, input logic [63:0] bytes, input int n,
                         input bit addrOk, input string req);
    bit ack;
    settling = 1'b1;
    i2cStart();
    sendByte(addr, ack);
    chk(ack == addrOk, "R1", ack, addrOk);
    if (ack) begin
      for (int k = 0; k < n; k++) begin
        logic [7:0] b;
        b = bytes[63-8*k -: 8];
        sendByte(b, ack);
        chk(ack, req, ack, 1);
        if (k >= 2 && k < 5) mReg[k-2] = b;
      end
    end
    i2cStop();
    chk(sdaOe == 1'b0, "R11", sdaOe, 0);
    repeat (10) @(posedge clk);
    repeat (4) @(negedge bufClk);
    #0.5;
    settling = 1'b0;
  endtask

  task automatic readCheck(input string req);
    bit ack;
    logic [7:0] d;
    i2cStart();
    sendByte(8'hD3, ack);
    chk(ack, "R1", ack, 1);
    for (int k = 0; k < 4; k++) begin
      recvByte(k < 3, d);
      chk(d == mReg[k % 3], req, d, mReg[k % 3]);
    end
    i2cStop();
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=completion");
      finishRun();
    end
  end

  initial begin
    for (int r = 0; r < 3; r++) mReg[r] = 8'hFF;
    repeat (5) @(posedge clk);
    #0.5;
    rstN = 1'b1;
    repeat (3) @(posedge clk);
    #0.5;
    settling = 1'b0;
    // R6: reset state
    chk(sdaOe == 1'b0, "R6", sdaOe, 0);
    repeat (6) @(posedge bufClk);
    readCheck("R6");

    // R2/R7: full write, reserved bits read back
    writeTx(8'hD2, 64'hAA55_A57C_3C00_0000, 5, 1'b1, "R2");
    @(posedge bufClk); #2;
    chk(clkOut == {2'b01, 8'h3C, 8'hA5}, "R7", clkOut, {2'b01, 8'h3C, 8'hA5});
    @(negedge bufClk); #2;
    chk(clkOut == 18'h0, "R8", clkOut, 0);
    readCheck("R5");
    readCheck("R7");

    // R3: stop after the first data byte
    writeTx(8'hD2, 64'h0102_0000_0000_0000, 3, 1'b1, "R3");
    readCheck("R3");
    // R2: dummy bytes only change nothing
    writeTx(8'hD2, 64'h1122_0000_0000_0000, 2, 1'b1, "R2");
    readCheck("R2");

    // R4: overlong write
    writeTx(8'hD2, 64'hFFFF_FF80_0100_0000, 7, 1'b1, "R4");
    mReg[0] = 8'hFF; mReg[1] = 8'h80; mReg[2] = 8'h01;
    readCheck("R4");

    // R1: foreign address ignored
    writeTx(8'hD4, 64'h0, 0, 1'b0, "R1");
    readCheck("R1");

    // R10: float all outputs
    floatN = 1'b0;
    repeat (6) @(posedge bufClk);
    #2;
    chk(clkDrive == 18'h0, "R10", clkDrive, 0);
    @(posedge clk); #0.5;
    floatN = 1'b1;
    repeat (4) @(posedge bufClk);
    #2;
    chk(clkDrive == 18'h3FFFF, "R10", clkDrive, 18'h3FFFF);

    chk(runtCnt == 0, "R9", runtCnt, 0);
    chk(sdaBadCnt == 0, "R11", sdaBadCnt, 0);
    finishRun();
  end
endmodule